// File: doc/BRIEF.md
# Multifunction Status Pin Controller

This block owns a single shared output pin on a dual-channel frequency synthesizer and decides, from a 4-bit function code, what that pin does. The pin can report lock status, follow the output pulses of any reference or feedback divider for bench measurements, or act as an open-drain pull-down switch during fast lock. The same function code also produces the hold signals that park each channel's two dividers at their load point.

A configuration interface presents a new function code on `sel_in` and pulses `sel_latch`. Nothing changes until that strobe arrives. Each channel's reference and feedback holds come from one register stage, so a held pair starts counting again on the same clock edge.

In fast-lock mode, a rising fast-lock request while the loop is unlocked raises the charge-pump current select and pulls the pin low. Lock ends the episode: the current select drops back and the pin is released.

Top module: `mfpin_ctrl`

## Requirements
- R1: The active function code is 0 after reset. It takes the value of `sel_in` only on a clock edge where `sel_latch` is high. Any other change of `sel_in` has no effect on the outputs.
- R2: Code 4+c (c < NUM_CH) sets both `hold_ref[c]` and `hold_fb[c]` and no other hold bit. Hold outputs follow the active code one clock later.
- R3: Code 1 sets every bit of `hold_ref` and `hold_fb`.
- R4: For every channel, `hold_ref[c]` always equals `hold_fb[c]`. Leaving a reset code releases both on the same edge.
- R5: Code 8+2c routes `ref_pulse[c]` to `pin_drv`, and code 9+2c routes `fb_pulse[c]` to it, with `pin_od` low.
- R6: Code 0 drives `pin_drv` with `lock_det`, with `pin_od` low and no holds.
- R7: With code 2 active, a rising edge of `fastlock_req` while `lock_det` is low sets `cp_hi` on the next edge. While `cp_hi` is set, `pin_od` is 1 and `pin_drv` is 0 (pull-down on).
- R8: With fast lock active, `lock_det` high clears `cp_hi` on the next edge. The pin is then released (`pin_od`=1, `pin_drv`=1).
- R9: Fast lock does not start if the request rises while locked, or if the request is held steady. Latching a code other than 2 ends it immediately.
- R10: Codes 3, 4+c for c >= NUM_CH, and codes 8+2·NUM_CH through 15 drive `pin_drv` low with `pin_od` low and set no hold. Reset codes 1 and 4+c also drive the pin low in push-pull.
- R11: `cp_hi` and `pin_od` are high only while code 2 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_in | input | 4 | Function code presented by configuration |
| sel_latch | input | 1 | Strobe that loads `sel_in` |
| fastlock_req | input | 1 | Fast-lock request; a rising edge starts an episode |
| lock_det | input | 1 | Loop lock status |
| ref_pulse | input | NUM_CH | Reference divider output pulses per channel |
| fb_pulse | input | NUM_CH | Feedback divider output pulses per channel |
| pin_drv | output | 1 | Pin value (in open-drain mode: 0 = pull down, 1 = released) |
| pin_od | output | 1 | Pin is in open-drain mode |
| hold_ref | output | NUM_CH | Reference divider held at load point, per channel |
| hold_fb | output | NUM_CH | Feedback divider held at load point, per channel |
| cp_hi | output | 1 | Charge-pump current select, high = fast-lock setting |

## Verification
The bench builds the block with the default NUM_CH = 2. At that size the 16 function codes split into used and unused codes that can all be visited. Every code is swept against all 32 combinations of `lock_det` and the four divider pulses, so each routing path, each hold pattern and each unused code is compared with an arithmetic model. The fast-lock episode is then driven through entry, exit on lock, blocked entry while locked, a request held steady, and abandonment by a new code.

// File: rtl/mfpin_pkg.sv
package mfpin_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t C_NORMAL   = 4'd0;
  localparam code_t C_RST_ALL  = 4'd1;
  localparam code_t C_FASTLOCK = 4'd2;
  localparam int    RST_BASE   = 4;
  localparam int    MON_BASE   = 8;

  typedef enum logic [2:0] {
    K_NORMAL,
    K_RST_ALL,
    K_FASTLOCK,
    K_RST_CH,
    K_MON,
    K_UNUSED
  } kind_t;

  // Classify a function code for a build with nch channels.
  function automatic kind_t code_kind(code_t c, int nch);
    int v;
    v = int'(c);
    if (c == C_NORMAL)                          return K_NORMAL;
    if (c == C_RST_ALL)                         return K_RST_ALL;
    if (c == C_FASTLOCK)                        return K_FASTLOCK;
    if (v >= RST_BASE && v < RST_BASE + nch)    return K_RST_CH;
    if (v >= MON_BASE && v < MON_BASE + 2*nch)  return K_MON;
    return K_UNUSED;
  endfunction

  // Channel index carried by a per-channel reset or monitor code.
  function automatic int code_chan(code_t c);
    int v;
    v = int'(c);
    if (v >= MON_BASE) return (v - MON_BASE) / 2;
    return v - RST_BASE;
  endfunction

  // Monitor codes: odd selects the feedback divider, even the reference.
  function automatic logic code_is_fb(code_t c);
    return c[0];
  endfunction

  // True when channel ch must be parked under code c.
  function automatic logic chan_held(code_t c, int ch, int nch);
    kind_t k;
    k = code_kind(c, nch);
    return (k == K_RST_ALL) || (k == K_RST_CH && code_chan(c) == ch);
  endfunction
endpackage

// File: rtl/mfpin_cfg_latch.sv
module mfpin_cfg_latch
  import mfpin_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t sel_in,
  input  logic  sel_latch,
  output code_t cfg_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_code <= C_NORMAL;
    else if (sel_latch) cfg_code <= sel_in;
  end
endmodule

// File: rtl/mfpin_hold_dec.sv
module mfpin_hold_dec
  import mfpin_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  code_t             cfg_code,
  output logic [NUM_CH-1:0] hold_ref,
  output logic [NUM_CH-1:0] hold_fb
);
  logic [NUM_CH-1:0] hold_next;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign hold_next[ch] = chan_held(cfg_code, ch, NUM_CH);

    // One flop per divider, both loaded from the same decode term, so a
    // pair enters and leaves the held state on the same clock edge.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_ref[ch] <= 1'b0;
        hold_fb[ch]  <= 1'b0;
      end else begin
        hold_ref[ch] <= hold_next[ch];
        hold_fb[ch]  <= hold_next[ch];
      end
    end
  end
endmodule

// File: rtl/mfpin_fastlock.sv
module mfpin_fastlock (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_fl,
  input  logic fastlock_req,
  input  logic lock_det,
  output logic fl_on
);
  logic req_q;
  logic fl_q;
  logic req_rise;

  assign req_rise = fastlock_req & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      fl_q  <= 1'b0;
    end else begin
      req_q <= fastlock_req;
      fl_q  <= mode_fl & ~lock_det & (fl_q | req_rise);
    end
  end

  // Gate with the live mode so leaving the fast-lock code ends it at once.
  assign fl_on = fl_q & mode_fl;
endmodule

// File: rtl/mfpin_pin_mux.sv
module mfpin_pin_mux
  import mfpin_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  code_t             cfg_code,
  input  logic              lock_det,
  input  logic              fl_on,
  input  logic [NUM_CH-1:0] ref_pulse,
  input  logic [NUM_CH-1:0] fb_pulse,
  output logic              pin_drv,
  output logic              pin_od
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  kind_t           kind;
  logic [CH_W-1:0] sel_ch;

  assign kind   = code_kind(cfg_code, NUM_CH);
  assign sel_ch = CH_W'(code_chan(cfg_code));

  always_comb begin
    pin_drv = 1'b0;
    pin_od  = 1'b0;
    case (kind)
      K_NORMAL:   pin_drv = lock_det;
      K_FASTLOCK: begin
        pin_od  = 1'b1;
        pin_drv = ~fl_on;
      end
      K_MON:      pin_drv = code_is_fb(cfg_code) ? fb_pulse[sel_ch]
                                                 : ref_pulse[sel_ch];
      default:    pin_drv = 1'b0;
    endcase
  end
endmodule

// File: rtl/mfpin_ctrl.sv
module mfpin_ctrl
  import mfpin_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        sel_in,
  input  logic              sel_latch,
  input  logic              fastlock_req,
  input  logic              lock_det,
  input  logic [NUM_CH-1:0] ref_pulse,
  input  logic [NUM_CH-1:0] fb_pulse,
  output logic              pin_drv,
  output logic              pin_od,
  output logic [NUM_CH-1:0] hold_ref,
  output logic [NUM_CH-1:0] hold_fb,
  output logic              cp_hi
);
  code_t cfg_code;
  logic  mode_fl;
  logic  fl_on;

  mfpin_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .sel_in(sel_in),
    .sel_latch(sel_latch), .cfg_code(cfg_code)
  );

  assign mode_fl = (cfg_code == C_FASTLOCK);

  mfpin_hold_dec #(.NUM_CH(NUM_CH)) u_hold (
    .clk(clk), .rst_n(rst_n), .cfg_code(cfg_code),
    .hold_ref(hold_ref), .hold_fb(hold_fb)
  );

  mfpin_fastlock u_fl (
    .clk(clk), .rst_n(rst_n), .mode_fl(mode_fl),
    .fastlock_req(fastlock_req), .lock_det(lock_det), .fl_on(fl_on)
  );

  mfpin_pin_mux #(.NUM_CH(NUM_CH)) u_mux (
    .cfg_code(cfg_code), .lock_det(lock_det), .fl_on(fl_on),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .pin_drv(pin_drv), .pin_od(pin_od)
  );

  assign cp_hi = fl_on;
endmodule

// File: rtl/mfpin_chk.sv
module mfpin_chk
  import mfpin_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_latch,
  input logic              lock_det,
  input code_t             cfg_code,
  input logic              pin_drv,
  input logic              pin_od,
  input logic [NUM_CH-1:0] hold_ref,
  input logic [NUM_CH-1:0] hold_fb,
  input logic              cp_hi
);
  assert_code_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_latch |=> $stable(cfg_code));

  assert_pair_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ref == hold_fb);

  assert_pull_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cp_hi |-> (pin_od && !pin_drv));

  assert_lock_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_hi && lock_det) |=> !cp_hi);

  assert_unused_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (code_kind(cfg_code, NUM_CH) == K_UNUSED) |-> (!pin_drv && !pin_od));

  assert_cp_only_fl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cp_hi |-> (cfg_code == C_FASTLOCK));

  assert_od_only_fl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pin_od |-> (cfg_code == C_FASTLOCK));
endmodule

bind mfpin_ctrl mfpin_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_latch(sel_latch), .lock_det(lock_det),
  .cfg_code(cfg_code), .pin_drv(pin_drv), .pin_od(pin_od),
  .hold_ref(hold_ref), .hold_fb(hold_fb), .cp_hi(cp_hi)
);

// File: tb/sim_mfpin_ctrl.sv
`timescale 1ns/1ps
module sim_mfpin_ctrl;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [3:0]     sel_in = '0;
  logic           sel_latch = 1'b0;
  logic           fastlock_req = 1'b0;
  logic           lock_det = 1'b0;
  logic [NCH-1:0] ref_pulse = '0;
  logic [NCH-1:0] fb_pulse = '0;
  logic           pin_drv, pin_od, cp_hi;
  logic [NCH-1:0] hold_ref, hold_fb;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mfpin_ctrl #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .sel_latch(sel_latch),
    .fastlock_req(fastlock_req), .lock_det(lock_det),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .pin_drv(pin_drv), .pin_od(pin_od),
    .hold_ref(hold_ref), .hold_fb(hold_fb), .cp_hi(cp_hi)
  );

  // Packed view of outputs: {cp_hi, hold_fb, hold_ref, pin_od, pin_drv}
  function automatic logic [6:0] observed();
    return {cp_hi, hold_fb, hold_ref, pin_od, pin_drv};
  endfunction

  // Model of the outputs with fast lock idle, restated from the requirements.
  function automatic logic [6:0] model(int code, logic lk,
                                       logic [1:0] rp, logic [1:0] fp);
    logic drv, od;
    logic [1:0] h;
    drv = 1'b0; od = 1'b0; h = 2'b00;
    if (code == 0) drv = lk;
    else if (code == 1) h = 2'b11;
    else if (code == 2) begin od = 1'b1; drv = 1'b1; end
    else if (code >= 4 && code < 4 + NCH) h = 2'(1 << (code - 4));
    else if (code >= 8 && code < 8 + 2*NCH)
      drv = (code % 2 == 1) ? fp[(code-8)/2] : rp[(code-8)/2];
    return {1'b0, h, h, od, drv};
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Load a code and wait until the registered holds have followed it.
  task automatic load(int code);
    @(negedge clk);
    sel_in = 4'(code);
    sel_latch = 1'b1;
    @(negedge clk);
    sel_latch = 1'b0;
    @(negedge clk);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R6: reset state is the normal code
    check("R1", observed(), model(0, 1'b0, 2'b00, 2'b00));
    lock_det = 1'b1; #1;
    check("R6", observed(), model(0, 1'b1, 2'b00, 2'b00));
    lock_det = 1'b0;

    // R2 R3 R5 R6 R10: sweep every code against every input pattern
    for (int code = 0; code < 16; code++) begin
      load(code);
      for (int p = 0; p < 32; p++) begin
        lock_det  = p[4];
        ref_pulse = p[1:0];
        fb_pulse  = p[3:2];
        #1;
        check("R2/R3/R5/R6/R10", observed(),
              model(code, p[4], p[1:0], p[3:2]));
      end
    end
    lock_det = 1'b0; ref_pulse = '0; fb_pulse = '0;

    // R1: sel_in changes without a strobe are ignored
    load(8);
    ref_pulse = 2'b01;
    @(negedge clk); sel_in = 4'd1;
    repeat (3) @(negedge clk);
    check("R1", observed(), model(8, 1'b0, 2'b01, 2'b00));
    ref_pulse = '0;

    // R4: leaving a per-channel reset releases both dividers together
    load(5);
    check("R4", observed(), model(5, 1'b0, 2'b00, 2'b00));
    load(0);
    check("R4", observed(), model(0, 1'b0, 2'b00, 2'b00));

    // R7: fast-lock entry on a request edge while unlocked
    load(2);
    fastlock_req = 1'b1;
    @(negedge clk);
    check("R7", observed(), 7'b1_00_00_10);
    @(negedge clk);
    check("R7", observed(), 7'b1_00_00_10);

    // R8: lock ends fast lock and releases the pin
    lock_det = 1'b1;
    @(negedge clk);
    check("R8", observed(), 7'b0_00_00_11);

    // R9: a request held high does not restart after lock is lost
    lock_det = 1'b0;
    repeat (2) @(negedge clk);
    check("R9", observed(), 7'b0_00_00_11);

    // R9: a request edge while locked does not start fast lock
    fastlock_req = 1'b0;
    lock_det = 1'b1;
    @(negedge clk);
    fastlock_req = 1'b1;
    @(negedge clk);
    check("R9", observed(), 7'b0_00_00_11);

    // R9 / R11: a new code ends an active episode at once
    lock_det = 1'b0; fastlock_req = 1'b0;
    @(negedge clk);
    fastlock_req = 1'b1;
    @(negedge clk);
    check("R7", observed(), 7'b1_00_00_10);
    sel_in = 4'd0; sel_latch = 1'b1;
    @(negedge clk);
    sel_latch = 1'b0;
    check("R11", observed(), 7'b0_00_00_00);
    repeat (2) @(negedge clk);
    check("R9", observed(), 7'b0_00_00_00);
    fastlock_req = 1'b0;

    report();
  end
endmodule